// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a processor whose datapath control signals come from a microprogram store rather than from random logic. A microaddress register selects a word of an internal read-only store. The selected word is captured in a microword register. The control bits of that register drive the datapath, and its sequencing bits choose the next microaddress. An opcode decoder turns the current instruction's opcode into the first microaddress of that instruction's routine. A condition input from the datapath steers conditional microbranches.

A parameter picks one of two timings. In the serial variant a microword is read in one cycle and applied in the next, so each microword takes two cycles. In the overlapped variant the store is read for the following microword while the current one is being applied. The next address is worked out ahead from the word leaving the store, on the assumption that a conditional branch is not taken. A taken branch discards the word fetched in advance, which costs one idle cycle.

Top module: `microseq_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ctlOut` is 0 and `opStart` is low. The first microword applied after reset is the one at address 0. A reset in the middle of a run restarts the sequence from address 0.
- R2: A microword holds its control bits in its top CTL_W bits, a 2-bit mode below them (0 increment, 1 jump, 2 branch on condition, 3 dispatch through the opcode decoder), and an ADDR_W-bit target field in its lowest bits.
- R3: Store contents. Address 0 holds control 0x01 with mode increment. Address 1 holds control 0x02 with mode dispatch. For opcode k, the routine at base 4+4k holds four words: control 0x10|k with increment; control 0x20|k with branch to base+3; control 0x40|k with increment; control 0x80|k with jump to 0. Every other address holds control 0x00 with jump to 0.
- R4: After an increment word, the next word applied is the one at the following address. After a jump word, the next word applied is the one at the target field.
- R5: `cond` is sampled in the cycle a branch word is applied. If it is 1, the next word applied is the one at the target field. If it is 0, the next word applied is the one at the following address.
- R6: After a dispatch word, the next word applied is the one at address 4+4k, where k is `opcode`. The opcode must be held steady from the cycle the dispatch word is read from the store until that routine starts.
- R7: With PIPELINED=1, after an increment, jump, dispatch or not-taken branch, the next microword is applied in the very next cycle.
- R8: With PIPELINED=1, a taken branch is followed by exactly one cycle with `ctlOut` 0 and `opStart` low. The target word is applied in the cycle after that.
- R9: With PIPELINED=0, each microword is applied for one cycle and is followed by one cycle with `ctlOut` 0 and `opStart` low.
- R10: `opStart` is high exactly in the cycles in which the first word of an opcode routine is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OP_W | Opcode of the current instruction, consumed by dispatch |
| cond | input | 1 | Datapath condition tested by branch microwords |
| ctlOut | output | CTL_W | Control signals of the microword being applied, 0 when none is applied |
| opStart | output | 1 | High while the first microword of an instruction routine is applied |

## Verification
The assertions assume that `rst` is held high across at least one clock edge, and that `opcode` does not change between the store read of a dispatch word and the start of the routine it selects. `cond` is allowed to change on any cycle, because it is only meaningful while a branch word is applied. The bench gives each of the two instances, serial and overlapped, its own opcode and condition. It changes an opcode only in the cycle its instance reports a routine start. It toggles the condition every cycle with fixed all-zero, all-one or random patterns, so both branch outcomes are covered without breaking the opcode hold rule.

// File: rtl/microseq_pkg.sv
package microseq_pkg;

  typedef enum logic [1:0] {
    MODE_INC      = 2'd0,
    MODE_JUMP     = 2'd1,
    MODE_BRANCH   = 2'd2,
    MODE_DISPATCH = 2'd3
  } seqMode_e;

  typedef enum logic [2:0] {
    NXT_HOLD      = 3'd0,
    NXT_INC       = 3'd1,
    NXT_ROMFIELD  = 3'd2,
    NXT_CSIRFIELD = 3'd3,
    NXT_DECODE    = 3'd4
  } nextSel_e;

  // strobes from sequencing control to the address/word path
  typedef struct packed {
    logic     loadWord;
    nextSel_e nextSel;
  } seqStrobe_t;

endpackage

// File: rtl/microseq_store.sv
module microseq_store
  import microseq_pkg::*;
#(
  parameter int CTL_W   = 8,
  parameter int ADDR_W  = 6,
  parameter int OP_W    = 3,
  parameter int RT_BASE = 4,
  localparam int WORD_W = CTL_W + 2 + ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] word
);

  localparam int NUM_OPS = 1 << OP_W;
  localparam logic [ADDR_W:0]   RT_LO  = (ADDR_W+1)'(RT_BASE);
  localparam logic [ADDR_W:0]   RT_HI  = (ADDR_W+1)'(RT_BASE + 4 * NUM_OPS);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RT_BASE);

  logic [ADDR_W-1:0] rel;
  logic [OP_W-1:0]   opIdx;
  logic [1:0]        step;
  logic [CTL_W-1:0]  ctl;
  seqMode_e          mode;
  logic [ADDR_W-1:0] field;
  logic              inRoutine;

  assign inRoutine = ({1'b0, addr} >= RT_LO) && ({1'b0, addr} < RT_HI);
  assign rel       = addr - BASE_A;
  assign step      = rel[1:0];
  assign opIdx     = rel[OP_W+1:2];

  always_comb begin
    ctl   = '0;
    mode  = MODE_JUMP;
    field = '0;
    if (addr == '0) begin
      ctl  = CTL_W'(8'h01);
      mode = MODE_INC;
    end else if (addr == ADDR_W'(1)) begin
      ctl  = CTL_W'(8'h02);
      mode = MODE_DISPATCH;
    end else if (inRoutine) begin
      case (step)
        2'd0: begin
          ctl  = CTL_W'(8'h10) | CTL_W'(opIdx);
          mode = MODE_INC;
        end
        2'd1: begin
          ctl   = CTL_W'(8'h20) | CTL_W'(opIdx);
          mode  = MODE_BRANCH;
          field = addr + ADDR_W'(2);
        end
        2'd2: begin
          ctl  = CTL_W'(8'h40) | CTL_W'(opIdx);
          mode = MODE_INC;
        end
        default: begin
          ctl   = CTL_W'(8'h80) | CTL_W'(opIdx);
          mode  = MODE_JUMP;
          field = '0;
        end
      endcase
    end
  end

  assign word = {ctl, mode, field};

endmodule

// File: rtl/microseq_path.sv
module microseq_path
  import microseq_pkg::*;
#(
  parameter int CTL_W   = 8,
  parameter int ADDR_W  = 6,
  parameter int OP_W    = 3,
  parameter int RT_BASE = 4,
  localparam int WORD_W = CTL_W + 2 + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  seqStrobe_t        strobe,
  input  logic [WORD_W-1:0] romWord,
  output logic [ADDR_W-1:0] csar,
  output logic [WORD_W-1:0] csirWord,
  output logic              csirValid,
  output logic              csirDisp
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RT_BASE);

  logic [ADDR_W-1:0] dispatchAddr;
  logic [ADDR_W-1:0] nextCsar;
  logic              csarDisp;

  // opcode decoder: routine k starts at base + 4k
  assign dispatchAddr = BASE_A + ADDR_W'({opcode, 2'b00});

  always_comb begin
    case (strobe.nextSel)
      NXT_INC:       nextCsar = csar + ADDR_W'(1);
      NXT_ROMFIELD:  nextCsar = romWord[ADDR_W-1:0];
      NXT_CSIRFIELD: nextCsar = csirWord[ADDR_W-1:0];
      NXT_DECODE:    nextCsar = dispatchAddr;
      default:       nextCsar = csar;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csar      <= '0;
      csarDisp  <= 1'b0;
      csirWord  <= '0;
      csirValid <= 1'b0;
      csirDisp  <= 1'b0;
    end else begin
      if (strobe.nextSel != NXT_HOLD) begin
        csar     <= nextCsar;
        csarDisp <= (strobe.nextSel == NXT_DECODE);
      end
      if (strobe.loadWord) begin
        csirWord  <= romWord;
        csirValid <= 1'b1;
        csirDisp  <= csarDisp;
      end else begin
        csirValid <= 1'b0;
        csirDisp  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/microseq_ctrl.sv
module microseq_ctrl
  import microseq_pkg::*;
#(
  parameter bit PIPELINED = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cond,
  input  seqMode_e   romMode,
  input  seqMode_e   csirMode,
  input  logic       csirValid,
  output seqStrobe_t strobe
);

  generate
    if (PIPELINED) begin : g_overlap
      logic     loadW;
      nextSel_e sel;
      logic     unusedOverlap;
      assign unusedOverlap = clk ^ rst;

      always_comb begin
        loadW = 1'b1;
        sel   = NXT_INC;
        if (csirValid && (csirMode == MODE_BRANCH) && cond) begin
          // prefetched fall-through word is squashed
          loadW = 1'b0;
          sel   = NXT_CSIRFIELD;
        end else begin
          case (romMode)
            MODE_JUMP:     sel = NXT_ROMFIELD;
            MODE_DISPATCH: sel = NXT_DECODE;
            default:       sel = NXT_INC;
          endcase
        end
      end
      assign strobe = '{loadWord: loadW, nextSel: sel};
    end else begin : g_serial
      logic     applyPhase;
      logic     loadW;
      nextSel_e sel;
      logic     unusedSerial;
      assign unusedSerial = csirValid ^ (^romMode);

      always_ff @(posedge clk) begin
        if (rst) applyPhase <= 1'b0;
        else     applyPhase <= ~applyPhase;
      end

      always_comb begin
        loadW = 1'b0;
        sel   = NXT_HOLD;
        if (!applyPhase) begin
          loadW = 1'b1;
        end else begin
          case (csirMode)
            MODE_JUMP:     sel = NXT_CSIRFIELD;
            MODE_BRANCH:   sel = cond ? NXT_CSIRFIELD : NXT_INC;
            MODE_DISPATCH: sel = NXT_DECODE;
            default:       sel = NXT_INC;
          endcase
        end
      end
      assign strobe = '{loadWord: loadW, nextSel: sel};
    end
  endgenerate

endmodule

// File: rtl/microseq_unit.sv
module microseq_unit
  import microseq_pkg::*;
#(
  parameter int CTL_W     = 8,
  parameter int ADDR_W    = 6,
  parameter int OP_W      = 3,
  parameter int RT_BASE   = 4,
  parameter bit PIPELINED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  input  logic             cond,
  output logic [CTL_W-1:0] ctlOut,
  output logic             opStart
);

  localparam int WORD_W = CTL_W + 2 + ADDR_W;

  logic [ADDR_W-1:0] csar;
  logic [WORD_W-1:0] romWord;
  logic [WORD_W-1:0] csirWord;
  logic              csirValid;
  logic              csirDisp;
  logic [1:0]        csirMode;
  logic [ADDR_W-1:0] csirField;
  seqStrobe_t        strobe;

  assign csirMode  = csirWord[ADDR_W+1:ADDR_W];
  assign csirField = csirWord[ADDR_W-1:0];

  microseq_store #(.CTL_W(CTL_W), .ADDR_W(ADDR_W), .OP_W(OP_W), .RT_BASE(RT_BASE)) u_store (
    .addr (csar),
    .word (romWord)
  );

  microseq_path #(.CTL_W(CTL_W), .ADDR_W(ADDR_W), .OP_W(OP_W), .RT_BASE(RT_BASE)) u_path (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .strobe    (strobe),
    .romWord   (romWord),
    .csar      (csar),
    .csirWord  (csirWord),
    .csirValid (csirValid),
    .csirDisp  (csirDisp)
  );

  microseq_ctrl #(.PIPELINED(PIPELINED)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cond      (cond),
    .romMode   (seqMode_e'(romWord[ADDR_W+1:ADDR_W])),
    .csirMode  (seqMode_e'(csirMode)),
    .csirValid (csirValid),
    .strobe    (strobe)
  );

  assign ctlOut  = csirValid ? csirWord[WORD_W-1:ADDR_W+2] : '0;
  assign opStart = csirDisp;

endmodule

// File: rtl/microseq_unit_chk.sv
module microseq_unit_chk #(
  parameter int CTL_W     = 8,
  parameter int ADDR_W    = 6,
  parameter int OP_W      = 3,
  parameter int RT_BASE   = 4,
  parameter bit PIPELINED = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   opcode,
  input logic              cond,
  input logic [CTL_W-1:0]  ctlOut,
  input logic              opStart,
  input logic [ADDR_W-1:0] csar,
  input logic              csirValid,
  input logic [1:0]        csirMode,
  input logic [ADDR_W-1:0] csirField
);

  // R1: nothing applied in the cycle right after reset falls
  a_r1_quiet_on_release: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctlOut == '0 && !opStart));

  // R10: a routine start always carries a real microword
  a_r10_start_applied: assert property (@(posedge clk) disable iff (rst)
    opStart |-> (csirValid && ctlOut != '0));

  // R5: taken branch redirects the address register to the target
  a_r5_taken_target: assert property (@(posedge clk) disable iff (rst)
    (csirValid && csirMode == 2'd2 && cond) |=> (csar == $past(csirField)));

  // R8 / R9: an idle cycle is always followed by an applied word
  a_r8_idle_then_word: assert property (@(posedge clk) disable iff (rst)
    (!csirValid && !$fell(rst)) |=> csirValid);

  a_r2_mode_known: assert property (@(posedge clk) disable iff (rst)
    csirValid |-> !$isunknown(csirMode));

  generate
    if (PIPELINED) begin : g_overlapChk
      logic unusedChk;
      assign unusedChk = ^opcode;

      // R7: no gap unless a branch is taken
      a_r7_no_gap: assert property (@(posedge clk) disable iff (rst)
        (csirValid && !(csirMode == 2'd2 && cond)) |=> csirValid);

      // R8: a taken branch leaves exactly one empty cycle
      a_r8_one_bubble: assert property (@(posedge clk) disable iff (rst)
        (csirValid && csirMode == 2'd2 && cond) |=> !csirValid);
    end else begin : g_serialChk
      // R9: applied words alternate with empty cycles
      a_r9_alternate: assert property (@(posedge clk) disable iff (rst)
        csirValid |=> !csirValid);

      // R4: jump loads the target field
      a_r4_jump_target: assert property (@(posedge clk) disable iff (rst)
        (csirValid && csirMode == 2'd1) |=> (csar == $past(csirField)));

      // R6: dispatch loads base + 4*opcode
      a_r6_dispatch_addr: assert property (@(posedge clk) disable iff (rst)
        (csirValid && csirMode == 2'd3) |=>
          (csar == ADDR_W'(RT_BASE) + ADDR_W'({$past(opcode), 2'b00})));
    end
  endgenerate

endmodule

bind microseq_unit microseq_unit_chk #(
  .CTL_W(CTL_W), .ADDR_W(ADDR_W), .OP_W(OP_W), .RT_BASE(RT_BASE), .PIPELINED(PIPELINED)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .opcode    (opcode),
  .cond      (cond),
  .ctlOut    (ctlOut),
  .opStart   (opStart),
  .csar      (csar),
  .csirValid (csirValid),
  .csirMode  (csirMode),
  .csirField (csirField)
);

// File: tb/microseq_unit_bench.sv
`timescale 1ns/1ps
module microseq_unit_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] opP = '0, opS = '0;
  logic       condP = 1'b0, condS = 1'b0;
  logic [7:0] ctlP, ctlS;
  logic       startP, startS;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  microseq_unit #(.PIPELINED(1'b1)) u_microseq_unit (
    .clk(clk), .rst(rst), .opcode(opP), .cond(condP), .ctlOut(ctlP), .opStart(startP));

  microseq_unit #(.PIPELINED(1'b0)) u_microseq_unit_serial (
    .clk(clk), .rst(rst), .opcode(opS), .cond(condS), .ctlOut(ctlS), .opStart(startS));

  // microprogram as stated by R3 (layout per R2)
  function automatic int bCtl(input int a);
    int k, s;
    if (a == 0) return 'h01;
    if (a == 1) return 'h02;
    if (a >= 4 && a < 36) begin
      k = (a - 4) / 4; s = (a - 4) % 4;
      case (s)
        0: return 'h10 | k;
        1: return 'h20 | k;
        2: return 'h40 | k;
        default: return 'h80 | k;
      endcase
    end
    return 0;
  endfunction

  function automatic int bMode(input int a);
    if (a == 0) return 0;
    if (a == 1) return 3;
    if (a >= 4 && a < 36) begin
      case ((a - 4) % 4)
        1: return 2;
        3: return 1;
        default: return 0;
      endcase
    end
    return 1;
  endfunction

  function automatic int bField(input int a);
    if (a >= 4 && a < 36 && ((a - 4) % 4) == 1) return a + 2;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench-side expectation state
  bit    pValid, pDisp;  int pAddr, pTarget;  string pWhy;
  bit    sApply, sDisp;  int sAddr;           string sWhy;
  int    condPol, opPol;
  int    opSeqP, opSeqS;

  function automatic logic pickCond();
    if (condPol == 0) return 1'b0;
    if (condPol == 1) return 1'b1;
    return logic'($urandom % 2);
  endfunction

  task automatic pickOpP();
    if (opPol == 0) begin opSeqP = (opSeqP + 1) % 8; opP = 3'(opSeqP); end
    else opP = 3'($urandom % 8);
  endtask

  task automatic pickOpS();
    if (opPol == 0) begin opSeqS = (opSeqS + 1) % 8; opS = 3'(opSeqS); end
    else opS = 3'($urandom % 8);
  endtask

  task automatic stepPipe();
    int eCtl; bit eStart; int m;
    eCtl   = pValid ? bCtl(pAddr) : 0;
    eStart = pValid ? pDisp : 1'b0;
    check(ctlP == 8'(eCtl), pValid ? {pWhy, " R3 overlap"} : "R8 bubble", int'(ctlP), eCtl);
    check(startP == eStart, "R10 overlap", int'(startP), int'(eStart));
    condP = pickCond();
    if (pValid && pDisp) pickOpP();
    if (!pValid) begin
      pValid = 1'b1; pAddr = pTarget; pDisp = 1'b0; pWhy = "R5 R8 target";
    end else begin
      m = bMode(pAddr);
      pDisp = 1'b0;
      case (m)
        0: begin pAddr = pAddr + 1; pWhy = "R4 R7 inc"; end
        1: begin pAddr = bField(pAddr); pWhy = "R4 R7 jump"; end
        2: begin
          if (condP) begin pValid = 1'b0; pTarget = bField(pAddr); end
          else begin pAddr = pAddr + 1; pWhy = "R5 R7 fallthrough"; end
        end
        default: begin pAddr = 4 + 4 * int'(opP); pDisp = 1'b1; pWhy = "R6 R7 dispatch"; end
      endcase
    end
  endtask

  task automatic stepSerial();
    int eCtl; bit eStart; int m;
    eCtl   = sApply ? bCtl(sAddr) : 0;
    eStart = sApply ? sDisp : 1'b0;
    check(ctlS == 8'(eCtl), sApply ? {sWhy, " R3 R9 serial"} : "R9 idle", int'(ctlS), eCtl);
    check(startS == eStart, "R10 serial", int'(startS), int'(eStart));
    condS = pickCond();
    if (sApply && sDisp) pickOpS();
    if (sApply) begin
      m = bMode(sAddr);
      sDisp = 1'b0;
      case (m)
        0: begin sAddr = sAddr + 1; sWhy = "R4 inc"; end
        1: begin sAddr = bField(sAddr); sWhy = "R4 jump"; end
        2: begin
          if (condS) begin sAddr = bField(sAddr); sWhy = "R5 taken"; end
          else begin sAddr = sAddr + 1; sWhy = "R5 fallthrough"; end
        end
        default: begin sAddr = 4 + 4 * int'(opS); sDisp = 1'b1; sWhy = "R6 dispatch"; end
      endcase
      sApply = 1'b0;
    end else begin
      sApply = 1'b1;
    end
  endtask

  task automatic checkResetQuiet();
    check(ctlP == 8'h00 && !startP, "R1 reset overlap", int'(ctlP), 0);
    check(ctlS == 8'h00 && !startS, "R1 reset serial", int'(ctlS), 0);
  endtask

  task automatic runSeg(input int cPol, input int oPol, input int n);
    condPol = cPol; opPol = oPol;
    opSeqP = 0; opSeqS = 0;
    opP = (oPol == 0) ? 3'd0 : 3'($urandom % 8);
    opS = (oPol == 0) ? 3'd0 : 3'($urandom % 8);
    condP = pickCond(); condS = pickCond();
    pValid = 1'b1; pAddr = 0; pDisp = 1'b0; pWhy = "R1 first";
    sApply = 1'b1; sAddr = 0; sDisp = 1'b0; sWhy = "R1 first";
    rst = 1'b0;
    repeat (n) begin
      @(negedge clk);
      stepPipe();
      stepSerial();
    end
  endtask

  task automatic resetPulse();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) begin
      @(negedge clk);
      checkResetQuiet();
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) begin
      @(negedge clk);
      checkResetQuiet();
    end
    // directed: every branch falls through, opcodes in order
    runSeg(0, 0, 160);
    resetPulse();
    // directed: every branch taken, opcodes in order
    runSeg(1, 0, 160);
    resetPulse();
    // random mix
    runSeg(2, 1, 2400);
    resetPulse();
    runSeg(2, 1, 600);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule